// File: doc/BRIEF.md
# Five-State Snooping Line-Coherence Agent

This block keeps the coherence state of every line in a small direct-mapped cache that belongs to one agent of a multi-agent snooping system. Each line is invalid, shared, exclusive, forwarding or modified. The agent serves local read, write and evict requests. It asks the interconnect for a line with a read, for ownership with a read-for-ownership, or gives up dirty data with a writeback. It also answers snoops from other agents with a registered reply. The reply says whether this agent holds a copy, whether it will supply the data, and whether that data is dirty and must also reach memory.

One clean sharer, the forwarding copy, answers read snoops with data. Plain sharers stay silent, so every request gets at most one data reply. A snoop arriving in a cycle has priority over a local request. Only one interconnect transaction may be outstanding at a time. Each line holds one data word, so a write replaces the whole line.

Addresses are line addresses. The low `log2(NUM_LINES)` bits select the slot and the remaining bits form the tag.

Top module: `coh_line_agent`

## Requirements
- R1: After reset every slot is invalid. No bus request and no responses are pending, `cpu_req_ready` is 1, and a snoop to any address reports `snp_rsp_shared`=0 and `snp_rsp_supply`=0.
- R2: A read miss issues a bus request with op code 1 (read). When the reply arrives, the line is filled with `bus_resp_data`, which is also returned to the CPU. The new state is exclusive when both `bus_resp_shared` and `bus_resp_fwd` are 0, and forwarding when either of them is 1.
- R3: A read that hits returns the stored word with `cpu_resp_valid` one cycle after acceptance, and no bus request is made.
- R4: A write that hits an exclusive or modified line stores the word, makes the line modified, and responds one cycle after acceptance with no bus request.
- R5: A write that hits a shared or forwarding line issues a bus request with op code 2 (read-for-ownership). When the reply arrives, the line becomes modified and holds the written word.
- R6: A write miss issues op code 2. When the reply arrives, the line is installed modified and holds the written word.
- R7: A read snoop that hits sets `snp_rsp_shared`. A modified, exclusive or forwarding holder also sets `snp_rsp_supply` and puts the line on `snp_rsp_data`. A modified holder also sets `snp_rsp_dirty`. Every holder drops to shared. A plain shared holder supplies nothing. The reply appears one cycle after the snoop.
- R8: An ownership snoop (`snp_rfo`=1) that hits makes the line invalid. Supply and dirty follow the same rules as for a read snoop.
- R9: Evicting a modified line issues op code 3 (writeback) carrying the line data, and the line becomes invalid after the reply. Evicting a clean line, or a line that is not present, makes no bus request and responds after one cycle.
- R10: A read or write miss whose slot holds a modified line with another tag first writes that line back (op code 3, victim address and data) and only then issues the miss request. A clean victim is overwritten silently.
- R11: While `snp_valid` is 1, no local request is accepted. The snoop is answered, and the local request is taken once the snoop is gone.
- R12: While a bus request is pending, `cpu_req_ready` is 0. `bus_req_valid`, `bus_req_op` and `bus_req_addr` hold steady until `bus_resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Local request present |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_req_addr | input | ADDR_W | Line address of the local request |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_req_ready | output | 1 | Local request accepted this cycle if valid |
| cpu_resp_valid | output | 1 | Local request completed |
| cpu_resp_rdata | output | DATA_W | Read data (or written word) |
| snp_valid | input | 1 | Snoop from another agent |
| snp_rfo | input | 1 | 1 ownership snoop, 0 read snoop |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_rsp_valid | output | 1 | Snoop reply present |
| snp_rsp_supply | output | 1 | This agent supplies the data |
| snp_rsp_shared | output | 1 | This agent held a copy |
| snp_rsp_dirty | output | 1 | Supplied data is dirty; memory must take it |
| snp_rsp_data | output | DATA_W | Supplied line data |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_op | output | 2 | 1 read, 2 read-for-ownership, 3 writeback |
| bus_req_addr | output | ADDR_W | Request line address |
| bus_req_data | output | DATA_W | Writeback data |
| bus_resp_valid | input | 1 | Completion of the pending request |
| bus_resp_data | input | DATA_W | Fill data for a read |
| bus_resp_shared | input | 1 | Another agent keeps a copy |
| bus_resp_fwd | input | 1 | Data came from another cache |

## Verification
The embedded properties assume that `bus_resp_valid` pulses only while `bus_req_valid` is high. They also assume that no snoop targets the address of this agent's own pending miss, because resolving such conflicts belongs to the home agent. The directed bench plays the interconnect itself: it answers only the request it observes, one reply per request. It snoops only lines whose local transaction has completed, or lines in other slots. It drives at most one snoop per cycle and never uses the reserved local op code.

// File: rtl/coh_pkg.sv
// Shared types for the line-coherence agent.
// Assumes: state and op encodings below are fixed; ports carry them as plain vectors.
package coh_pkg;

    typedef enum logic [2:0] {
        LS_INV = 3'd0,
        LS_SHR = 3'd1,
        LS_EXC = 3'd2,
        LS_FWD = 3'd3,
        LS_MOD = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        BOP_NONE = 2'd0,
        BOP_READ = 2'd1,
        BOP_RFO  = 2'd2,
        BOP_WB   = 2'd3
    } bus_op_e;

    localparam logic [1:0] CPU_RD = 2'd0;
    localparam logic [1:0] CPU_WR = 2'd1;
    localparam logic [1:0] CPU_EV = 2'd2;

    // True when a holder in this state must answer a snoop with data.
    function automatic logic st_supplies(line_st_e s);
        return (s == LS_MOD) || (s == LS_EXC) || (s == LS_FWD);
    endfunction

endpackage

// File: rtl/coh_line_store.sv
// Per-slot state, tag and data registers.
// Two combinational read ports (snoop side A, CPU side B) and two write ports.
// Port A (snoop) only changes state and wins over port B on the same slot.
// Assumes NUM_LINES is a power of two; only state is reset.
module coh_line_store
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = $clog2(NUM_LINES),
    parameter int TAG_W     = 7,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output line_st_e          ra_state,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output line_st_e          rb_state,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  line_st_e          wa_state,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  line_st_e          wb_state,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data
);

    line_st_e          st_q  [NUM_LINES];
    logic [TAG_W-1:0]  tag_q [NUM_LINES];
    logic [DATA_W-1:0] dat_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_slot
        // Slot state: snoop write first, then local/fill write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= LS_INV;
            end else if (wa_en && wa_idx == IDX_W'(g)) begin
                st_q[g] <= wa_state;
            end else if (wb_en && wb_idx == IDX_W'(g)) begin
                st_q[g] <= wb_state;
            end
        end

        // Slot tag and data: written only by the local/fill port.
        always_ff @(posedge clk) begin
            if (wb_en && wb_idx == IDX_W'(g)) begin
                tag_q[g] <= wb_tag;
                dat_q[g] <= wb_data;
            end
        end
    end

    // Combinational read ports.
    always_comb begin
        ra_state = st_q[ra_idx];
        ra_tag   = tag_q[ra_idx];
        ra_data  = dat_q[ra_idx];
        rb_state = st_q[rb_idx];
        rb_tag   = tag_q[rb_idx];
        rb_data  = dat_q[rb_idx];
    end

    // R7/R8: a snoop may only demote a slot, never grant ownership.
    a_r7_snoop_only_demotes: assert property (@(posedge clk) disable iff (!rst_n)
        wa_en |-> (wa_state == LS_INV || wa_state == LS_SHR));

endmodule

// File: rtl/coh_snoop_resp.sv
// Snoop decision and registered snoop reply.
// Decides the new slot state combinationally and registers the reply for one cycle.
// Assumes the caller supplies the slot state/data read for the snooped index.
module coh_snoop_resp
    import coh_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic              snp_rfo,
    input  line_st_e          line_state,
    input  logic              tag_hit,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_en,
    output line_st_e          upd_state,
    output logic              rsp_valid,
    output logic              rsp_supply,
    output logic              rsp_shared,
    output logic              rsp_dirty,
    output logic [DATA_W-1:0] rsp_data
);

    logic hit;
    logic give;

    // Hit detection and next state for the snooped slot.
    always_comb begin
        hit       = snp_valid && tag_hit && (line_state != LS_INV);
        give      = hit && st_supplies(line_state);
        upd_en    = hit;
        upd_state = snp_rfo ? LS_INV : LS_SHR;
    end

    // Registered reply, one cycle after the snoop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_supply <= 1'b0;
            rsp_shared <= 1'b0;
            rsp_dirty  <= 1'b0;
            rsp_data   <= '0;
        end else begin
            rsp_valid  <= snp_valid;
            rsp_supply <= give;
            rsp_shared <= hit;
            rsp_dirty  <= hit && (line_state == LS_MOD);
            rsp_data   <= give ? line_data : '0;
        end
    end

    // R7: dirty data is always supplied, and only inside a reply.
    a_r7_dirty_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dirty |-> (rsp_supply && rsp_shared && rsp_valid));

endmodule

// File: rtl/coh_miss_seq.sv
// Sequencer for the single outstanding bus transaction.
// Optionally performs a victim writeback, then the read or ownership request,
// and produces the slot fill and the local completion.
// Assumes bus_resp_valid arrives only while bus_req_valid is high.
module coh_miss_seq
    import coh_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = ADDR_W - IDX_W,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wb,
    input  logic              start_wb_only,
    input  bus_op_e           start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] victim_addr,
    input  logic [DATA_W-1:0] victim_data,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              bus_resp_valid,
    input  logic [DATA_W-1:0] bus_resp_data,
    input  logic              bus_resp_shared,
    input  logic              bus_resp_fwd,
    output logic              busy,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    output logic              fill_en,
    output logic [IDX_W-1:0]  fill_idx,
    output line_st_e          fill_state,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [DATA_W-1:0] fill_data,
    output logic              done,
    output logic [DATA_W-1:0] done_data
);

    typedef enum logic [1:0] {PH_IDLE, PH_WB, PH_REQ} phase_e;

    phase_e            phase_q;
    bus_op_e           op_q;
    logic              wb_only_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] vaddr_q;
    logic [DATA_W-1:0] vdata_q;
    logic [DATA_W-1:0] wdata_q;

    // Phase register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            op_q      <= BOP_NONE;
            wb_only_q <= 1'b0;
            addr_q    <= '0;
            vaddr_q   <= '0;
            vdata_q   <= '0;
            wdata_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q   <= start_wb ? PH_WB : PH_REQ;
                    op_q      <= start_op;
                    wb_only_q <= start_wb_only;
                    addr_q    <= start_addr;
                    vaddr_q   <= victim_addr;
                    vdata_q   <= victim_data;
                    wdata_q   <= start_wdata;
                end
                PH_WB:   if (bus_resp_valid) phase_q <= wb_only_q ? PH_IDLE : PH_REQ;
                PH_REQ:  if (bus_resp_valid) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Bus request outputs follow the registered phase.
    always_comb begin
        busy          = (phase_q != PH_IDLE);
        bus_req_valid = busy;
        bus_req_op    = (phase_q == PH_WB) ? BOP_WB : (busy ? op_q : BOP_NONE);
        bus_req_addr  = (phase_q == PH_WB) ? vaddr_q : addr_q;
        bus_req_data  = (phase_q == PH_WB) ? vdata_q : '0;
    end

    // Slot fill and local completion on each bus reply.
    always_comb begin
        fill_en    = 1'b0;
        fill_idx   = addr_q[IDX_W-1:0];
        fill_state = LS_INV;
        fill_tag   = addr_q[ADDR_W-1:IDX_W];
        fill_data  = wdata_q;
        done       = 1'b0;
        done_data  = wdata_q;
        if (bus_resp_valid && phase_q == PH_WB) begin
            fill_en   = 1'b1;
            fill_tag  = vaddr_q[ADDR_W-1:IDX_W];
            fill_data = vdata_q;
            done      = wb_only_q;
            done_data = vdata_q;
        end else if (bus_resp_valid && phase_q == PH_REQ) begin
            fill_en = 1'b1;
            done    = 1'b1;
            if (op_q == BOP_READ) begin
                fill_state = (bus_resp_shared || bus_resp_fwd) ? LS_FWD : LS_EXC;
                fill_data  = bus_resp_data;
                done_data  = bus_resp_data;
            end else begin
                fill_state = LS_MOD;
            end
        end
    end

    // R12: a pending request holds steady until its reply.
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_resp_valid) |=>
            (bus_req_valid && $stable(bus_req_op) && $stable(bus_req_addr)));

    // R10: a victim writeback for a miss is followed by the miss request itself.
    a_r10_wb_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_op == BOP_WB && bus_resp_valid && !done) |=>
            (bus_req_valid && bus_req_op != BOP_WB));

endmodule

// File: rtl/coh_line_agent.sv
// Top of the line-coherence agent: local request decode, snoop path,
// storage and bus sequencer.
// Assumes: one snoop per cycle; no snoop to the address of the agent's own
// pending miss; cpu_req_op value 3 is treated as a no-op.
module coh_line_agent
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic [1:0]        cpu_req_op,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    input  logic              snp_valid,
    input  logic              snp_rfo,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_rsp_valid,
    output logic              snp_rsp_supply,
    output logic              snp_rsp_shared,
    output logic              snp_rsp_dirty,
    output logic [DATA_W-1:0] snp_rsp_data,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_resp_valid,
    input  logic [DATA_W-1:0] bus_resp_data,
    input  logic              bus_resp_shared,
    input  logic              bus_resp_fwd
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    // Storage wiring.
    line_st_e          sn_state, cu_state;
    logic [TAG_W-1:0]  sn_tag, cu_tag;
    logic [DATA_W-1:0] sn_data, cu_data;
    logic              sn_upd_en;
    line_st_e          sn_upd_state;

    // Sequencer wiring.
    logic              seq_busy;
    logic              fill_en;
    logic [IDX_W-1:0]  fill_idx;
    line_st_e          fill_state;
    logic [TAG_W-1:0]  fill_tag;
    logic [DATA_W-1:0] fill_data;
    logic              seq_done;
    logic [DATA_W-1:0] seq_done_data;

    // Local decode.
    logic              accept, cpu_hit;
    logic              need_bus, need_wb, wb_only;
    bus_op_e           miss_op;
    logic              loc_upd;
    line_st_e          loc_state;
    logic [DATA_W-1:0] loc_data;
    logic              wb_en;
    logic [IDX_W-1:0]  wb_idx;
    line_st_e          wb_state;
    logic [TAG_W-1:0]  wb_tag;
    logic [DATA_W-1:0] wb_data;

    // Snoop has priority; only one bus transaction at a time.
    always_comb begin
        cpu_req_ready = !snp_valid && !seq_busy;
        accept        = cpu_req_valid && cpu_req_ready;
        cpu_hit       = (cu_state != LS_INV) && (cu_tag == cpu_req_addr[ADDR_W-1:IDX_W]);
    end

    // Classify the local request into a silent update or a bus transaction.
    always_comb begin
        need_bus  = 1'b0;
        need_wb   = 1'b0;
        wb_only   = 1'b0;
        miss_op   = BOP_READ;
        loc_upd   = 1'b0;
        loc_state = cu_state;
        loc_data  = cu_data;
        case (cpu_req_op)
            CPU_RD: if (!cpu_hit) begin
                need_bus = 1'b1;
                need_wb  = (cu_state == LS_MOD);
            end
            CPU_WR: begin
                miss_op = BOP_RFO;
                if (cpu_hit && (cu_state == LS_EXC || cu_state == LS_MOD)) begin
                    loc_upd   = 1'b1;
                    loc_state = LS_MOD;
                    loc_data  = cpu_req_wdata;
                end else begin
                    need_bus = 1'b1;
                    need_wb  = !cpu_hit && (cu_state == LS_MOD);
                end
            end
            CPU_EV: if (cpu_hit && cu_state == LS_MOD) begin
                need_bus = 1'b1;
                need_wb  = 1'b1;
                wb_only  = 1'b1;
            end else if (cpu_hit) begin
                loc_upd   = 1'b1;
                loc_state = LS_INV;
            end
            default: ;
        endcase
    end

    // Local/fill write port: fills only while busy, local updates only while idle.
    always_comb begin
        wb_en    = fill_en || (accept && loc_upd);
        wb_idx   = fill_en ? fill_idx   : cpu_req_addr[IDX_W-1:0];
        wb_state = fill_en ? fill_state : loc_state;
        wb_tag   = fill_en ? fill_tag   : cpu_req_addr[ADDR_W-1:IDX_W];
        wb_data  = fill_en ? fill_data  : loc_data;
    end

    // Local completion register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_resp_valid <= 1'b0;
            cpu_resp_rdata <= '0;
        end else begin
            cpu_resp_valid <= (accept && !need_bus) || seq_done;
            if (seq_done)
                cpu_resp_rdata <= seq_done_data;
            else if (accept)
                cpu_resp_rdata <= (cpu_req_op == CPU_WR) ? cpu_req_wdata : cu_data;
        end
    end

    coh_line_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (snp_addr[IDX_W-1:0]),
        .ra_state (sn_state),
        .ra_tag   (sn_tag),
        .ra_data  (sn_data),
        .rb_idx   (cpu_req_addr[IDX_W-1:0]),
        .rb_state (cu_state),
        .rb_tag   (cu_tag),
        .rb_data  (cu_data),
        .wa_en    (sn_upd_en),
        .wa_idx   (snp_addr[IDX_W-1:0]),
        .wa_state (sn_upd_state),
        .wb_en    (wb_en),
        .wb_idx   (wb_idx),
        .wb_state (wb_state),
        .wb_tag   (wb_tag),
        .wb_data  (wb_data)
    );

    coh_snoop_resp #(
        .DATA_W (DATA_W)
    ) u_snoop (
        .clk        (clk),
        .rst_n      (rst_n),
        .snp_valid  (snp_valid),
        .snp_rfo    (snp_rfo),
        .line_state (sn_state),
        .tag_hit    (sn_tag == snp_addr[ADDR_W-1:IDX_W]),
        .line_data  (sn_data),
        .upd_en     (sn_upd_en),
        .upd_state  (sn_upd_state),
        .rsp_valid  (snp_rsp_valid),
        .rsp_supply (snp_rsp_supply),
        .rsp_shared (snp_rsp_shared),
        .rsp_dirty  (snp_rsp_dirty),
        .rsp_data   (snp_rsp_data)
    );

    coh_miss_seq #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (accept && need_bus),
        .start_wb        (need_wb),
        .start_wb_only   (wb_only),
        .start_op        (miss_op),
        .start_addr      (cpu_req_addr),
        .victim_addr     ({cu_tag, cpu_req_addr[IDX_W-1:0]}),
        .victim_data     (cu_data),
        .start_wdata     (cpu_req_wdata),
        .bus_resp_valid  (bus_resp_valid),
        .bus_resp_data   (bus_resp_data),
        .bus_resp_shared (bus_resp_shared),
        .bus_resp_fwd    (bus_resp_fwd),
        .busy            (seq_busy),
        .bus_req_valid   (bus_req_valid),
        .bus_req_op      (bus_req_op),
        .bus_req_addr    (bus_req_addr),
        .bus_req_data    (bus_req_data),
        .fill_en         (fill_en),
        .fill_idx        (fill_idx),
        .fill_state      (fill_state),
        .fill_tag        (fill_tag),
        .fill_data       (fill_data),
        .done            (seq_done),
        .done_data       (seq_done_data)
    );

    // R4: a write hit on an owned line completes next cycle without bus traffic.
    a_r4_silent_owned_write: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_req_op == CPU_WR && cpu_hit && (cu_state == LS_EXC || cu_state == LS_MOD))
            |=> (cpu_resp_valid && !bus_req_valid));

    // R11: a local request that meets a snoop is not taken in that cycle.
    a_r11_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && cpu_req_valid && !bus_req_valid) |=> (!cpu_resp_valid && !bus_req_valid));

endmodule

// File: tb/sim_coh_line_agent.sv
// Directed bench: the bench plays the interconnect and the other agents.
module sim_coh_line_agent;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req_valid = 1'b0;
    logic [1:0]        cpu_req_op = 2'd0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_wdata = '0;
    logic              cpu_req_ready, cpu_resp_valid;
    logic [DATA_W-1:0] cpu_resp_rdata;
    logic              snp_valid = 1'b0, snp_rfo = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_rsp_valid, snp_rsp_supply, snp_rsp_shared, snp_rsp_dirty;
    logic [DATA_W-1:0] snp_rsp_data;
    logic              bus_req_valid;
    logic [1:0]        bus_req_op;
    logic [ADDR_W-1:0] bus_req_addr;
    logic [DATA_W-1:0] bus_req_data;
    logic              bus_resp_valid = 1'b0;
    logic [DATA_W-1:0] bus_resp_data = '0;
    logic              bus_resp_shared = 1'b0, bus_resp_fwd = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    coh_line_agent u0 (.*);

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [ADDR_W-1:0] la(input int tag, input int idx);
        return {7'(tag), 3'(idx)};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_go(input logic [1:0] op, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_op    = op;
        cpu_req_addr  = a;
        cpu_req_wdata = wd;
        @(posedge clk);
        #1;
        cpu_req_valid = 1'b0;
    endtask

    task automatic serve(input string req, input logic [1:0] eop, input logic [ADDR_W-1:0] ea,
                         input logic [DATA_W-1:0] d, input logic sh, input logic fw,
                         output logic [DATA_W-1:0] got);
        int waited = 0;
        @(negedge clk);
        while (!bus_req_valid && waited < 16) begin
            @(negedge clk);
            waited++;
        end
        chk(req, "bus_req_valid", 64'(bus_req_valid), 64'd1);
        chk(req, "bus_req_op", 64'(bus_req_op), 64'(eop));
        chk(req, "bus_req_addr", 64'(bus_req_addr), 64'(ea));
        got = bus_req_data;
        bus_resp_valid  = 1'b1;
        bus_resp_data   = d;
        bus_resp_shared = sh;
        bus_resp_fwd    = fw;
        @(posedge clk);
        #1;
        bus_resp_valid  = 1'b0;
        bus_resp_shared = 1'b0;
        bus_resp_fwd    = 1'b0;
    endtask

    task automatic snoop(input logic rfo, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_rfo   = rfo;
        snp_addr  = a;
        @(posedge clk);
        #1;
        snp_valid = 1'b0;
    endtask

    task automatic snoop_expect(input string req, input logic rfo, input logic [ADDR_W-1:0] a,
                                input logic sh, input logic sup, input logic drt, input logic [DATA_W-1:0] d);
        snoop(rfo, a);
        chk(req, "snp_rsp_valid", 64'(snp_rsp_valid), 64'd1);
        chk(req, "snp_rsp_shared", 64'(snp_rsp_shared), 64'(sh));
        chk(req, "snp_rsp_supply", 64'(snp_rsp_supply), 64'(sup));
        chk(req, "snp_rsp_dirty", 64'(snp_rsp_dirty), 64'(drt));
        if (sup) chk(req, "snp_rsp_data", 64'(snp_rsp_data), 64'(d));
    endtask

    task automatic expect_resp(input string req, input logic [DATA_W-1:0] d);
        chk(req, "cpu_resp_valid", 64'(cpu_resp_valid), 64'd1);
        chk(req, "cpu_resp_rdata", 64'(cpu_resp_rdata), 64'(d));
        chk(req, "bus idle", 64'(bus_req_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1", "bus_req_valid", 64'(bus_req_valid), 64'd0);
        chk("R1", "cpu_resp_valid", 64'(cpu_resp_valid), 64'd0);
        chk("R1", "snp_rsp_valid", 64'(snp_rsp_valid), 64'd0);
        chk("R1", "cpu_req_ready", 64'(cpu_req_ready), 64'd1);
        snoop_expect("R1", 1'b0, la(0, 1), 1'b0, 1'b0, 1'b0, '0);
        snoop_expect("R1", 1'b0, la(5, 6), 1'b0, 1'b0, 1'b0, '0);
    endtask

    // Exclusive fill, silent write, hits, read snoop of modified, upgrade, ownership snoop.
    task automatic t_exclusive_path;
        logic [DATA_W-1:0] g;
        cpu_go(2'd0, la(1, 1), '0);
        serve("R2", 2'd1, la(1, 1), 32'hA1A1_0001, 1'b0, 1'b0, g);
        expect_resp("R2", 32'hA1A1_0001);
        cpu_go(2'd1, la(1, 1), 32'hB0B0_0002);
        expect_resp("R4", 32'hB0B0_0002);
        cpu_go(2'd0, la(1, 1), '0);
        expect_resp("R3", 32'hB0B0_0002);
        snoop_expect("R7 modified", 1'b0, la(1, 1), 1'b1, 1'b1, 1'b1, 32'hB0B0_0002);
        snoop_expect("R7 shared", 1'b0, la(1, 1), 1'b1, 1'b0, 1'b0, '0);
        cpu_go(2'd1, la(1, 1), 32'hC0C0_0003);
        serve("R5 shared", 2'd2, la(1, 1), '0, 1'b0, 1'b0, g);
        expect_resp("R5 shared", 32'hC0C0_0003);
        snoop_expect("R8 modified", 1'b1, la(1, 1), 1'b1, 1'b1, 1'b1, 32'hC0C0_0003);
        snoop_expect("R8 gone", 1'b0, la(1, 1), 1'b0, 1'b0, 1'b0, '0);
    endtask

    // Fill from another cache gives forwarding; forwarding answers once, then stays silent.
    task automatic t_forward_path;
        logic [DATA_W-1:0] g;
        cpu_go(2'd0, la(2, 2), '0);
        serve("R2 fwd", 2'd1, la(2, 2), 32'h2222_0000, 1'b0, 1'b1, g);
        expect_resp("R2 fwd", 32'h2222_0000);
        snoop_expect("R7 forward", 1'b0, la(2, 2), 1'b1, 1'b1, 1'b0, 32'h2222_0000);
        cpu_go(2'd0, la(2, 2), '0);
        expect_resp("R3 shared hit", 32'h2222_0000);
        snoop_expect("R8 shared", 1'b1, la(2, 2), 1'b1, 1'b0, 1'b0, '0);
        snoop_expect("R8 shared gone", 1'b0, la(2, 2), 1'b0, 1'b0, 1'b0, '0);
        cpu_go(2'd2, la(2, 2), '0);
        chk("R9 absent evict", "cpu_resp_valid", 64'(cpu_resp_valid), 64'd1);
        chk("R9 absent evict", "bus idle", 64'(bus_req_valid), 64'd0);
    endtask

    // Memory fill with sharers gives forwarding: a write then needs ownership.
    task automatic t_shared_memory_fill;
        logic [DATA_W-1:0] g;
        cpu_go(2'd0, la(3, 3), '0);
        serve("R2 sharers", 2'd1, la(3, 3), 32'h3333_0000, 1'b1, 1'b0, g);
        expect_resp("R2 sharers", 32'h3333_0000);
        cpu_go(2'd1, la(3, 3), 32'h3333_0001);
        serve("R5 forward", 2'd2, la(3, 3), '0, 1'b0, 1'b0, g);
        expect_resp("R5 forward", 32'h3333_0001);
        snoop_expect("R8 after upgrade", 1'b1, la(3, 3), 1'b1, 1'b1, 1'b1, 32'h3333_0001);
    endtask

    // Clean evict is silent; exclusive line answers a snoop clean.
    task automatic t_clean_evict;
        logic [DATA_W-1:0] g;
        cpu_go(2'd0, la(8, 5), '0);
        serve("R2", 2'd1, la(8, 5), 32'h5555_0000, 1'b0, 1'b0, g);
        snoop_expect("R7 exclusive", 1'b0, la(8, 5), 1'b1, 1'b1, 1'b0, 32'h5555_0000);
        cpu_go(2'd2, la(8, 5), '0);
        chk("R9 clean evict", "cpu_resp_valid", 64'(cpu_resp_valid), 64'd1);
        chk("R9 clean evict", "bus idle", 64'(bus_req_valid), 64'd0);
        snoop_expect("R9 clean evict", 1'b0, la(8, 5), 1'b0, 1'b0, 1'b0, '0);
    endtask

    // Write miss, victim writeback, then modified evict.
    task automatic t_write_miss_victim;
        logic [DATA_W-1:0] g;
        cpu_go(2'd1, la(4, 4), 32'h4444_0001);
        serve("R6", 2'd2, la(4, 4), '0, 1'b0, 1'b0, g);
        expect_resp("R6", 32'h4444_0001);
        cpu_go(2'd1, la(4, 4), 32'h4444_0002);
        expect_resp("R6 owned", 32'h4444_0002);
        cpu_go(2'd0, la(9, 4), '0);
        serve("R10 victim", 2'd3, la(4, 4), '0, 1'b0, 1'b0, g);
        chk("R10 victim", "wb data", 64'(g), 64'h4444_0002);
        chk("R10 victim", "no early resp", 64'(cpu_resp_valid), 64'd0);
        serve("R10 miss", 2'd1, la(9, 4), 32'h9999_0000, 1'b0, 1'b0, g);
        expect_resp("R10 miss", 32'h9999_0000);
        snoop_expect("R10 victim gone", 1'b0, la(4, 4), 1'b0, 1'b0, 1'b0, '0);
        cpu_go(2'd1, la(9, 4), 32'h9999_0001);
        expect_resp("R4 exclusive", 32'h9999_0001);
        cpu_go(2'd2, la(9, 4), '0);
        serve("R9 dirty evict", 2'd3, la(9, 4), '0, 1'b0, 1'b0, g);
        chk("R9 dirty evict", "wb data", 64'(g), 64'h9999_0001);
        chk("R9 dirty evict", "cpu_resp_valid", 64'(cpu_resp_valid), 64'd1);
        snoop_expect("R9 dirty evict", 1'b0, la(9, 4), 1'b0, 1'b0, 1'b0, '0);
    endtask

    // Snoop and local request in the same cycle.
    task automatic t_snoop_priority;
        logic [DATA_W-1:0] g;
        cpu_go(2'd0, la(6, 6), '0);
        serve("R11 setup", 2'd1, la(6, 6), 32'h6666_0000, 1'b0, 1'b0, g);
        @(negedge clk);
        snp_valid     = 1'b1;
        snp_rfo       = 1'b0;
        snp_addr      = la(3, 7);
        cpu_req_valid = 1'b1;
        cpu_req_op    = 2'd0;
        cpu_req_addr  = la(6, 6);
        #1;
        chk("R11", "cpu_req_ready", 64'(cpu_req_ready), 64'd0);
        @(posedge clk);
        #1;
        snp_valid = 1'b0;
        chk("R11", "snp_rsp_valid", 64'(snp_rsp_valid), 64'd1);
        chk("R11", "cpu_resp_valid", 64'(cpu_resp_valid), 64'd0);
        @(posedge clk);
        #1;
        cpu_req_valid = 1'b0;
        expect_resp("R11 later", 32'h6666_0000);
    endtask

    // One outstanding miss; request held until its reply.
    task automatic t_single_outstanding;
        logic [DATA_W-1:0] g;
        cpu_go(2'd0, la(7, 7), '0);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_op    = 2'd0;
        cpu_req_addr  = la(6, 6);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R12", "cpu_req_ready", 64'(cpu_req_ready), 64'd0);
            chk("R12", "bus_req_addr", 64'(bus_req_addr), 64'(la(7, 7)));
            chk("R12", "cpu_resp_valid", 64'(cpu_resp_valid), 64'd0);
        end
        cpu_req_valid = 1'b0;
        serve("R12", 2'd1, la(7, 7), 32'h7777_0000, 1'b0, 1'b0, g);
        expect_resp("R12", 32'h7777_0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_exclusive_path();
        t_forward_path();
        t_shared_memory_fill();
        t_clean_evict();
        t_write_miss_victim();
        t_snoop_priority();
        t_single_outstanding();
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule